// File: doc/BRIEF.md
# Simultaneous-Sampling Multi-Channel Serial ADC Capture

This block runs a bank of serial-output ADCs that must all sample at the same instant. A strobe from the downstream serializer starts a frame. One common convert line is driven high for a short pulse, and the block then waits a fixed conversion time counted in system clock cycles. After that it lowers a shared chip-select and issues one serial clock that all converters share. Each converter returns its result MSB first on its own data line, so every channel is read in parallel over the same clock periods.

Every result is widened by one bit, which is the inverse of its least significant bit. This keeps the line code after the serializer from sitting at a constant level for long stretches. The widened results are packed into one wide holding word with channel 0 in the top slot. When the word has been updated, a single-cycle ready pulse is raised. The word then keeps its value until the next frame completes. This gives the serializer a full frame period to shift the word out at its own fixed rate. A strobe that arrives while a frame is still being captured is dropped and sets an overrun flag.

Top module: `simul_adc_capture`

## Requirements
- R1: While reset is held and directly after it is released: `adc_cnv` is low, `adc_cs_n` is high, `adc_sclk` is low, `word_ready` is low, `overrun` is low and `hold_word` is all zeros.
- R2: If `frame_start` is high at a clock edge while the block is idle, that edge accepts the strobe. `adc_cnv` rises at that same edge and stays high for exactly START_PW cycles. There is one convert line for all channels, and `adc_cs_n` stays high while `adc_cnv` is high.
- R3: `adc_cs_n` falls CONV_WAIT edges after the accepting edge. It stays low for SAMPLE_W serial periods of 2·SCLK_HALF cycles each. In each period `adc_sclk` is low for the first SCLK_HALF cycles and high for the second SCLK_HALF cycles. Data is sampled when `adc_sclk` rises, MSB first, and exactly SAMPLE_W bits are taken per channel.
- R4: Each channel's slot is SAMPLE_W+1 bits wide: the sample in the upper bits and the inverse of the sample's bit 0 in slot bit 0.
- R5: Line `adc_sdo[c]` carries channel c. Channel c occupies `hold_word[(NUM_CH-1-c)*(SAMPLE_W+1) +: SAMPLE_W+1]`, which puts channel 0 in the most significant slot.
- R6: `word_ready` is high for exactly one cycle. It starts at the edge CONV_WAIT + 2·SCLK_HALF·SAMPLE_W + 1 edges after the accepting edge, and `hold_word` takes its new value at that same edge.
- R7: `hold_word` changes only at the edge that raises `word_ready`. It keeps its value throughout the following capture.
- R8: A strobe seen from the accepting edge up to the last edge before `word_ready` rises starts nothing. It sets `overrun` at that edge, and `overrun` stays set until the next accepted strobe clears it. A strobe during the `word_ready` cycle is accepted.
- R9: Outside a readout, `adc_sclk` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Frame strobe from the serializer |
| adc_sdo | input | NUM_CH | Serial data from each converter, bit c = channel c |
| adc_cnv | output | 1 | Common convert-start pulse |
| adc_cs_n | output | 1 | Shared active-low chip-select |
| adc_sclk | output | 1 | Shared serial clock |
| hold_word | output | NUM_CH*(SAMPLE_W+1) | Packed, widened results |
| word_ready | output | 1 | One-cycle pulse when `hold_word` is updated |
| overrun | output | 1 | Set by a strobe during a capture |

## Verification
The bench keeps the full sixteen-channel, 16-bit geometry, so the 272-bit word, the slot ordering and the inverted pad bit are checked at their real sizes. CONV_WAIT is shortened to 20 cycles, START_PW is 3 and SCLK_HALF is 2. These values keep a frame under a hundred cycles, so dozens of random and directed frames fit in the run, and every edge of the convert pulse, chip-select and serial clock can be timed against the requirement formulas. A model of the converters in the bench latches its analog values on the rise of the convert line and changes them during the frame. Back-to-back strobes in the ready cycle and strobes during conversion and readout are exercised as well.

// File: rtl/simcap_pkg.sv
package simcap_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_READ = 2'd2,
    ST_DONE = 2'd3
  } cap_state_e;
endpackage

// File: rtl/cap_sequencer.sv
module cap_sequencer
  import simcap_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int CONV_WAIT = 100,
  parameter int START_PW  = 4,
  parameter int SCLK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_start,
  output logic adc_cnv,
  output logic adc_cs_n,
  output logic adc_sclk,
  output logic sample_en,
  output logic load_en,
  output logic overrun
);
  localparam int CW_W = $clog2(CONV_WAIT + 1);
  localparam int PH_W = $clog2(2 * SCLK_HALF);
  localparam int BT_W = $clog2(SAMPLE_W + 1);
  localparam logic [CW_W-1:0] CW_LAST   = CW_W'(CONV_WAIT - 1);
  localparam logic [CW_W-1:0] PW_LEN    = CW_W'(START_PW);
  localparam logic [PH_W-1:0] PH_SAMPLE = PH_W'(SCLK_HALF - 1);
  localparam logic [PH_W-1:0] PH_HIGH   = PH_W'(SCLK_HALF);
  localparam logic [PH_W-1:0] PH_LAST   = PH_W'(2 * SCLK_HALF - 1);
  localparam logic [BT_W-1:0] BT_LAST   = BT_W'(SAMPLE_W - 1);
  localparam logic [BT_W-1:0] BT_FULL   = BT_W'(SAMPLE_W);

  cap_state_e      st;
  logic [CW_W-1:0] cnt;
  logic [PH_W-1:0] ph;
  logic [BT_W-1:0] bt;
  logic            ovr_q;

  // Named events used by the logic and the assertions
  logic start_acc;
  logic strobe_busy;
  logic period_end;
  assign start_acc   = frame_start && (st == ST_IDLE);
  assign strobe_busy = frame_start && (st != ST_IDLE);
  assign period_end  = (st == ST_READ) && (ph == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
      ph  <= '0;
      bt  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (start_acc) begin
            st  <= ST_CONV;
            cnt <= '0;
          end
        end
        ST_CONV: begin
          if (cnt == CW_LAST) begin
            st <= ST_READ;
            ph <= '0;
            bt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_READ: begin
          if (period_end) begin
            ph <= '0;
            if (bt == BT_LAST) st <= ST_DONE;
            else bt <= bt + 1'b1;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        ST_DONE: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ovr_q <= 1'b0;
    else if (strobe_busy) ovr_q <= 1'b1;
    else if (start_acc)   ovr_q <= 1'b0;
  end

  assign adc_cnv   = (st == ST_CONV) && (cnt < PW_LEN);
  assign adc_cs_n  = (st != ST_READ);
  assign adc_sclk  = (st == ST_READ) && (ph >= PH_HIGH);
  assign sample_en = (st == ST_READ) && (ph == PH_SAMPLE);
  assign load_en   = (st == ST_DONE);
  assign overrun   = ovr_q;

  // Observation counters for the assertions
  logic [CW_W-1:0] cnv_len;
  logic [BT_W-1:0] shifted;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnv_len <= '0;
      shifted <= '0;
    end else begin
      cnv_len <= adc_cnv ? cnv_len + 1'b1 : '0;
      if (start_acc)      shifted <= '0;
      else if (sample_en) shifted <= shifted + 1'b1;
    end
  end

  a_r2_cnv_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_cnv) |-> cnv_len == PW_LEN);
  a_r2_no_read_in_cnv: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cnv |-> adc_cs_n);
  a_r3_bit_count: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |-> shifted == BT_FULL);
  a_r9_sclk_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    adc_cs_n |-> !adc_sclk);
  a_r8_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_busy |=> overrun);
  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_busy |=> !$rose(adc_cnv));
endmodule

// File: rtl/cap_lane.sv
module cap_lane #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_en,
  input  logic                sdo,
  output logic [SAMPLE_W-1:0] sample
);
  logic [SAMPLE_W-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sreg <= '0;
    else if (sample_en) sreg <= {sreg[SAMPLE_W-2:0], sdo};
  end

  assign sample = sreg;

  a_r3_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |=> sample[0] == $past(sdo));
  a_r3_hold_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(sample));
endmodule

// File: rtl/cap_assembler.sv
module cap_assembler #(
  parameter int NUM_CH   = 16,
  parameter int SAMPLE_W = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                load_en,
  input  logic [NUM_CH*SAMPLE_W-1:0]          lane_bus,
  output logic [NUM_CH*(SAMPLE_W+1)-1:0]      hold_word,
  output logic                                word_ready
);
  localparam int SLOT_W = SAMPLE_W + 1;
  localparam int WORD_W = NUM_CH * SLOT_W;

  // Slot layout: sample on top, inverted LSB as the padding bit
  function automatic logic [SLOT_W-1:0] widen(input logic [SAMPLE_W-1:0] s);
    return {s, ~s[0]};
  endfunction

  logic [WORD_W-1:0] next_word;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
    assign next_word[(NUM_CH-1-c)*SLOT_W +: SLOT_W] =
      widen(lane_bus[c*SAMPLE_W +: SAMPLE_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_word  <= '0;
      word_ready <= 1'b0;
    end else begin
      word_ready <= load_en;
      if (load_en) hold_word <= next_word;
    end
  end

  a_r6_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |=> !word_ready);
  a_r6_ready_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> word_ready);
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(hold_word));
  a_r4_pad_bit: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> hold_word[0] != hold_word[1]);
endmodule

// File: rtl/simul_adc_capture.sv
module simul_adc_capture #(
  parameter int NUM_CH    = 16,
  parameter int SAMPLE_W  = 16,
  parameter int CONV_WAIT = 100,
  parameter int START_PW  = 4,
  parameter int SCLK_HALF = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           frame_start,
  input  logic [NUM_CH-1:0]              adc_sdo,
  output logic                           adc_cnv,
  output logic                           adc_cs_n,
  output logic                           adc_sclk,
  output logic [NUM_CH*(SAMPLE_W+1)-1:0] hold_word,
  output logic                           word_ready,
  output logic                           overrun
);
  logic                         sample_en;
  logic                         load_en;
  logic [NUM_CH*SAMPLE_W-1:0]   lane_bus;

  cap_sequencer #(
    .SAMPLE_W (SAMPLE_W),
    .CONV_WAIT(CONV_WAIT),
    .START_PW (START_PW),
    .SCLK_HALF(SCLK_HALF)
  ) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .adc_cnv    (adc_cnv),
    .adc_cs_n   (adc_cs_n),
    .adc_sclk   (adc_sclk),
    .sample_en  (sample_en),
    .load_en    (load_en),
    .overrun    (overrun)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    cap_lane #(.SAMPLE_W(SAMPLE_W)) i_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .sample_en(sample_en),
      .sdo      (adc_sdo[c]),
      .sample   (lane_bus[c*SAMPLE_W +: SAMPLE_W])
    );
  end

  cap_assembler #(
    .NUM_CH  (NUM_CH),
    .SAMPLE_W(SAMPLE_W)
  ) i_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .lane_bus  (lane_bus),
    .hold_word (hold_word),
    .word_ready(word_ready)
  );

  a_r6_load_while_idle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> adc_cs_n && !adc_cnv);
endmodule

// File: tb/test_simul_adc_capture.sv
module test_simul_adc_capture;
  localparam int NCH  = 16;
  localparam int SW   = 16;
  localparam int CW   = 20;
  localparam int PW   = 3;
  localparam int HALF = 2;
  localparam int WW   = NCH * (SW + 1);
  localparam int READY_N = CW + SW * 2 * HALF + 2; // negedge index of ready
  localparam int CS_N    = CW + 1;                 // negedge index of cs_n low

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic frame_start = 1'b0;
  logic [NCH-1:0] adc_sdo = '0;
  logic adc_cnv, adc_cs_n, adc_sclk, word_ready, overrun;
  logic [WW-1:0] hold_word;

  always #2.5 clk = ~clk;

  simul_adc_capture #(
    .NUM_CH(NCH), .SAMPLE_W(SW), .CONV_WAIT(CW), .START_PW(PW), .SCLK_HALF(HALF)
  ) i_simul_adc_capture (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .adc_sdo(adc_sdo),
    .adc_cnv(adc_cnv), .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk),
    .hold_word(hold_word), .word_ready(word_ready), .overrun(overrun)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input logic [WW-1:0] act,
                     input logic [WW-1:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Converter model: values latched on the convert pulse, shifted out MSB first
  logic [SW-1:0] analog  [NCH];
  logic [SW-1:0] latched [NCH];
  int cnv_rises = 0;
  int kbit = 0;

  always @(posedge adc_cnv) begin
    cnv_rises++;
    for (int c = 0; c < NCH; c++) latched[c] = analog[c];
  end

  always @(negedge adc_cs_n or posedge adc_sclk) begin
    if (adc_sclk) begin
      #1;
      kbit = kbit + 1;
    end else begin
      kbit = 0;
    end
    for (int c = 0; c < NCH; c++)
      adc_sdo[c] = (kbit < SW) ? latched[c][SW-1-kbit] : 1'b0;
  end

  // Expected word: shift slots in from channel 0 downwards
  function automatic logic [WW-1:0] pack_expected(input logic [SW-1:0] v [NCH]);
    logic [WW-1:0] w = '0;
    for (int c = 0; c < NCH; c++) begin
      w = w << (SW + 1);
      w[SW:0] = {v[c], !v[c][0]};
    end
    return w;
  endfunction

  // Watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  logic [WW-1:0] prev_word = '0;

  // mode: 0 plain, 1 change analog mid frame, 2 extra strobe during readout,
  //       3 extra strobe during conversion
  task automatic run_frame(input int mode, input string tag);
    logic [SW-1:0] snap [NCH];
    logic [WW-1:0] exp_w;
    int n = 0, cnv_first = -1, cnv_cnt = 0, cs_first = -1, rdy_n = -1;
    int rises0, sclk_bad = 0, stable_bad = 0, cs_bad = 0;
    bit ovr_at1 = 1'b1;
    for (int c = 0; c < NCH; c++) snap[c] = analog[c];
    exp_w = pack_expected(snap);
    rises0 = cnv_rises;
    frame_start = 1'b1;
    while (rdy_n < 0 && n < 400) begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        frame_start = 1'b0;
        ovr_at1 = overrun;
      end
      if (mode == 1 && n == 5)
        for (int c = 0; c < NCH; c++) analog[c] = 16'($urandom);
      if ((mode == 2 && n == 40) || (mode == 3 && n == 4)) frame_start = 1'b1;
      if ((mode == 2 && n == 41) || (mode == 3 && n == 5)) frame_start = 1'b0;
      if (adc_cnv) begin
        cnv_cnt++;
        if (cnv_first < 0) cnv_first = n;
        if (!adc_cs_n) cs_bad++;
      end
      if (!adc_cs_n && cs_first < 0) cs_first = n;
      if (adc_cs_n && adc_sclk) sclk_bad++;
      if (word_ready) rdy_n = n;
      else if (hold_word != prev_word) stable_bad++;
    end
    chk(ovr_at1 == 1'b0, {"R8 overrun cleared by accepted strobe ", tag}, WW'(ovr_at1), '0);
    chk(cnv_first == 1 && cnv_cnt == PW, {"R2 convert pulse ", tag},
        WW'(cnv_cnt), WW'(PW));
    chk(cnv_rises - rises0 == 1 && cs_bad == 0, {"R2 one common convert ", tag},
        WW'(cnv_rises - rises0), WW'(1));
    chk(cs_first == CS_N, {"R3 chip-select timing ", tag}, WW'(cs_first), WW'(CS_N));
    chk(rdy_n == READY_N, {"R6 ready timing ", tag}, WW'(rdy_n), WW'(READY_N));
    chk(hold_word == exp_w, {"R4 R5 holding word ", tag}, hold_word, exp_w);
    chk(stable_bad == 0, {"R7 word stable during capture ", tag}, WW'(stable_bad), '0);
    chk(sclk_bad == 0, {"R9 sclk idle low ", tag}, WW'(sclk_bad), '0);
    chk(overrun == (mode >= 2), {"R8 overrun flag ", tag}, WW'(overrun), WW'(mode >= 2));
    prev_word = hold_word;
    @(negedge clk);
    chk(word_ready == 1'b0, {"R6 ready single cycle ", tag}, WW'(word_ready), '0);
    chk(hold_word == prev_word, {"R7 word kept after ready ", tag}, hold_word, prev_word);
  endtask

  // Back-to-back: strobe driven in the ready cycle itself
  task automatic back_to_back();
    int n = 0, rdy_n = -1, cnv_first = -1;
    for (int c = 0; c < NCH; c++) analog[c] = 16'($urandom);
    frame_start = 1'b1;
    while (rdy_n < 0 && n < 400) begin
      @(negedge clk);
      n++;
      if (n == 1) frame_start = 1'b0;
      if (word_ready) rdy_n = n;
    end
    frame_start = 1'b1;   // sampled at the edge that ends the ready cycle
    @(negedge clk);
    frame_start = 1'b0;
    cnv_first = adc_cnv ? 1 : 0;
    chk(cnv_first == 1, "R8 strobe in ready cycle accepted", WW'(cnv_first), WW'(1));
    chk(overrun == 1'b0, "R8 ready-cycle strobe is no overrun", WW'(overrun), '0);
    while (!word_ready) @(negedge clk);
    @(negedge clk);
    prev_word = hold_word;
  endtask

  initial begin
    void'($urandom(32'd4242));
    for (int c = 0; c < NCH; c++) analog[c] = '0;
    for (int c = 0; c < NCH; c++) latched[c] = '0;
    repeat (3) @(negedge clk);
    chk(adc_cnv == 0 && adc_cs_n == 1 && adc_sclk == 0 && word_ready == 0 &&
        overrun == 0 && hold_word == '0, "R1 reset state",
        {adc_cnv, adc_cs_n, adc_sclk, word_ready, overrun}, WW'(5'b01000));
    rst_n = 1'b1;
    @(negedge clk);
    chk(adc_cnv == 0 && adc_cs_n == 1 && adc_sclk == 0 && hold_word == '0,
        "R1 idle after reset", {adc_cnv, adc_cs_n, adc_sclk}, WW'(3'b010));

    // Directed corners
    for (int c = 0; c < NCH; c++) analog[c] = 16'h0000;
    run_frame(0, "all-zero");
    for (int c = 0; c < NCH; c++) analog[c] = 16'hFFFF;
    run_frame(0, "all-ones");
    for (int c = 0; c < NCH; c++) analog[c] = 16'(c) * 16'h1111 ^ 16'h8001;
    run_frame(0, "channel ramp");
    for (int c = 0; c < NCH; c++) analog[c] = (c % 2 == 0) ? 16'hAAAA : 16'h5555;
    run_frame(1, "alternating, changed mid frame");
    for (int c = 0; c < NCH; c++) analog[c] = 16'h0001 << c;
    run_frame(2, "walking one, strobe in readout");
    for (int c = 0; c < NCH; c++) analog[c] = ~(16'h0001 << c);
    run_frame(3, "walking zero, strobe in conversion");
    back_to_back();

    // Random frames
    for (int f = 0; f < 24; f++) begin
      for (int c = 0; c < NCH; c++) analog[c] = 16'($urandom);
      run_frame(f % 4, "random");
      repeat (int'($urandom % 4)) @(negedge clk);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule